// File: doc/BRIEF.md
# Programmable Product Term Array

This block is the programmable AND plane of one logic block. It takes 36 routed input signals and builds a field of 72 literals from them: the true and the inverted copy of each input. From that field it evaluates 87 product terms. Each term's literal-enable mask is configurable, so a term can use any subset of the 72 literals.

Eighty of the terms leave the block unchanged as general-purpose terms for the downstream allocator. The remaining seven are control terms:

- four output-enable terms, two serving the upper half of the macrocells and two serving the lower half;
- an asynchronous set term;
- an asynchronous reset term;
- a term that serves as a clock.

Each control term has its own polarity bit. With that bit set, a term built from inverted literals acts as an OR of the true inputs.

The configuration is a single 6271-bit image. It is loaded through a serial chain with a data bit, a shift enable and the block clock. A done flag reports when a full image has been shifted in. While the chain is shifting, every term output is held at 0, so downstream logic never sees a half-loaded plane.

Top module: `ptarr_top`

## Requirements
- R1: Literal index l < 36 is input in_i[l], and literal index l >= 36 is the inverse of input in_i[l-36].
- R2: A term is the AND of its enabled literals. A term with no literal enabled evaluates to 1.
- R3: A term that enables both the true and the inverted literal of the same input evaluates to 0 for every input value.
- R4: Terms 0 to 79 drive gen_pt_o bit for bit, term t on bit t, with no inversion.
- R5: Terms 80 and 81 drive oe_upper_o[0] and oe_upper_o[1]. Terms 82 and 83 drive oe_lower_o[0] and oe_lower_o[1].
- R6: Term 84 drives aset_o, term 85 drives areset_o and term 86 drives ptclk_o.
- R7: Control term k (term 80+k, for k = 0 to 6) leaves the block XORed with polarity bit k. With the polarity bit set, a term of inverted literals therefore gives the OR of the true inputs.
- R8: On each rising clock edge with shift_en_i high, sdi_i enters configuration bit 0 and every bit i moves to bit i+1. The enable for literal l of term t is bit t*72+l, and polarity bit k is bit 6264+k. The first bit shifted in of a 6271-bit load therefore ends at bit 6270.
- R9: cfg_done_o goes high at the edge that completes 6271 shifts since reset or since the last completed load. It goes low at the first shift edge of the next load.
- R10: While shift_en_i is high, every term output (gen_pt_o, oe_upper_o, oe_lower_o, aset_o, areset_o, ptclk_o) is 0.
- R11: Reset clears the configuration and cfg_done_o. After reset, with no shifting, every term output is 1 and cfg_done_o is 0.
- R12: While shift_en_i is low, sdi_i is ignored. The configuration and cfg_done_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the configuration chain |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_en_i | input | 1 | Shift one configuration bit per edge while high |
| sdi_i | input | 1 | Serial configuration data |
| in_i | input | 36 | Routed input signals |
| gen_pt_o | output | 80 | General-purpose product terms |
| oe_upper_o | output | 2 | Output-enable terms for the upper macrocell half |
| oe_lower_o | output | 2 | Output-enable terms for the lower macrocell half |
| aset_o | output | 1 | Asynchronous set term |
| areset_o | output | 1 | Asynchronous reset term |
| ptclk_o | output | 1 | Product term clock |
| cfg_done_o | output | 1 | Full configuration image loaded |

## Verification
The term outputs are combinational from in_i and from the stored image. The bench drives each input pattern on the falling edge and samples one nanosecond later, in the same half cycle. A new image takes effect at the rising edge of its last shift, so term checks after a load are made only after shift_en_i has been dropped on the following falling edge. cfg_done_o is registered. Its low value is sampled before the completing edge, its high value after that edge, and its drop after the first edge of the next load.

// File: rtl/ptarr_pkg.sv
package ptarr_pkg;
  // index of each control term inside the control group
  typedef enum int unsigned {
    SPC_OE0   = 0,
    SPC_OE1   = 1,
    SPC_OE2   = 2,
    SPC_OE3   = 3,
    SPC_SET   = 4,
    SPC_RESET = 5,
    SPC_CLK   = 6
  } spc_idx_e;

  localparam int unsigned N_CTL_EXTRA = 3; // set, reset, clock
endpackage

// File: rtl/ptarr_cfg_chain.sv
module ptarr_cfg_chain #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         sdi_i,
  output logic [W-1:0] cfg_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  cfg_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (shift_en_i) begin
      cfg_q <= {cfg_q[W-2:0], sdi_i};
      if (cnt_q == CW'(W - 1)) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        done_q <= 1'b0;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign done_o = done_q;

  p_shift_in_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> cfg_q[0] == $past(sdi_i));

  p_done_from_shift_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(shift_en_i));

  p_done_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && done_q) |=> !done_q);

  p_hold_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> ($stable(cfg_q) && $stable(done_q)));
endmodule

// File: rtl/ptarr_term.sv
module ptarr_term #(
  parameter int unsigned N_LIT = 72
) (
  input  logic [N_LIT-1:0] lit_i,
  input  logic [N_LIT-1:0] en_i,
  output logic             term_o
);
  // a disabled literal contributes a 1 to the AND
  assign term_o = &(lit_i | ~en_i);
endmodule

// File: rtl/ptarr_plane.sv
module ptarr_plane #(
  parameter int unsigned N_IN   = 36,
  parameter int unsigned N_TERM = 87
) (
  input  logic [N_IN-1:0]             in_i,
  input  logic [N_TERM*2*N_IN-1:0]    en_i,
  output logic [N_TERM-1:0]           term_o
);
  localparam int unsigned N_LIT = 2 * N_IN;

  logic [N_LIT-1:0] lit;
  assign lit = {~in_i, in_i};

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    ptarr_term #(.N_LIT(N_LIT)) u_term (
      .lit_i  (lit),
      .en_i   (en_i[t*N_LIT +: N_LIT]),
      .term_o (term_o[t])
    );
  end
endmodule

// File: rtl/ptarr_route.sv
module ptarr_route
  import ptarr_pkg::*;
#(
  parameter int unsigned N_GEN = 80,
  parameter int unsigned N_OE  = 4
) (
  input  logic [N_GEN+N_OE+N_CTL_EXTRA-1:0] term_i,
  input  logic [N_OE+N_CTL_EXTRA-1:0]       pol_i,
  input  logic                               blank_i,
  output logic [N_GEN-1:0]                   gen_o,
  output logic [N_OE/2-1:0]                  oe_upper_o,
  output logic [N_OE/2-1:0]                  oe_lower_o,
  output logic                               aset_o,
  output logic                               areset_o,
  output logic                               ptclk_o
);
  localparam int unsigned N_SPC  = N_OE + N_CTL_EXTRA;
  localparam int unsigned N_TERM = N_GEN + N_SPC;
  localparam int unsigned N_HALF = N_OE / 2;

  logic [N_SPC-1:0] spc;
  assign spc = blank_i ? '0 : (term_i[N_TERM-1 -: N_SPC] ^ pol_i);

  assign gen_o      = blank_i ? '0 : term_i[N_GEN-1:0];
  assign oe_upper_o = spc[0 +: N_HALF];
  assign oe_lower_o = spc[N_HALF +: N_HALF];
  assign aset_o     = spc[N_OE + 0];
  assign areset_o   = spc[N_OE + 1];
  assign ptclk_o    = spc[N_OE + 2];
endmodule

// File: rtl/ptarr_top.sv
module ptarr_top
  import ptarr_pkg::*;
#(
  parameter int unsigned N_IN  = 36,
  parameter int unsigned N_GEN = 80,
  parameter int unsigned N_OE  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              sdi_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_GEN-1:0]  gen_pt_o,
  output logic [N_OE/2-1:0] oe_upper_o,
  output logic [N_OE/2-1:0] oe_lower_o,
  output logic              aset_o,
  output logic              areset_o,
  output logic              ptclk_o,
  output logic              cfg_done_o
);
  localparam int unsigned N_LIT   = 2 * N_IN;
  localparam int unsigned N_SPC   = N_OE + N_CTL_EXTRA;
  localparam int unsigned N_TERM  = N_GEN + N_SPC;
  localparam int unsigned EN_W    = N_TERM * N_LIT;
  localparam int unsigned CFG_W   = EN_W + N_SPC;

  logic [CFG_W-1:0]  cfg;
  logic [N_TERM-1:0] term;

  ptarr_cfg_chain #(.W(CFG_W)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en_i),
    .sdi_i      (sdi_i),
    .cfg_o      (cfg),
    .done_o     (cfg_done_o)
  );

  ptarr_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_plane (
    .in_i   (in_i),
    .en_i   (cfg[EN_W-1:0]),
    .term_o (term)
  );

  ptarr_route #(.N_GEN(N_GEN), .N_OE(N_OE)) u_route (
    .term_i     (term),
    .pol_i      (cfg[CFG_W-1 -: N_SPC]),
    .blank_i    (shift_en_i),
    .gen_o      (gen_pt_o),
    .oe_upper_o (oe_upper_o),
    .oe_lower_o (oe_lower_o),
    .aset_o     (aset_o),
    .areset_o   (areset_o),
    .ptclk_o    (ptclk_o)
  );

  p_blank_shift_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |-> ({gen_pt_o, oe_upper_o, oe_lower_o, aset_o, areset_o, ptclk_o} == '0));
endmodule

// File: tb/ptarr_top_tb_top.sv
module ptarr_top_tb_top;
  localparam int unsigned N_IN   = 36;
  localparam int unsigned N_GEN  = 80;
  localparam int unsigned N_OE   = 4;
  localparam int unsigned N_SPC  = N_OE + 3;
  localparam int unsigned N_TERM = N_GEN + N_SPC;
  localparam int unsigned N_LIT  = 2 * N_IN;
  localparam int unsigned EN_W   = N_TERM * N_LIT;
  localparam int unsigned CFG_W  = EN_W + N_SPC;

  localparam logic [N_IN-1:0] VEC [8] = '{
    36'h0_0000_0000, 36'hF_FFFF_FFFF, 36'hA_AAAA_AAAA, 36'h5_5555_5555,
    36'h1_2345_6789, 36'hE_DCBA_9876, 36'h0_00FF_FF00, 36'h8_0000_0001
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic shift_en = 1'b0;
  logic sdi = 1'b0;
  logic [N_IN-1:0] in_v = '0;
  logic [N_GEN-1:0] gen_pt;
  logic [N_OE/2-1:0] oe_up, oe_lo;
  logic aset, areset, ptclk, done;

  int n_chk = 0;
  int n_fail = 0;
  logic finished = 1'b0;
  logic [CFG_W-1:0] img;

  always #10 clk = ~clk;

  ptarr_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .shift_en_i(shift_en), .sdi_i(sdi), .in_i(in_v),
    .gen_pt_o(gen_pt), .oe_upper_o(oe_up), .oe_lower_o(oe_lo),
    .aset_o(aset), .areset_o(areset), .ptclk_o(ptclk), .cfg_done_o(done)
  );

  function automatic logic [N_TERM-1:0] all_terms();
    return {ptclk, areset, aset, oe_lo, oe_up, gen_pt};
  endfunction

  function automatic logic [N_TERM-1:0] model(input logic [CFG_W-1:0] c, input logic [N_IN-1:0] x);
    logic [N_TERM-1:0] r;
    for (int t = 0; t < N_TERM; t++) begin
      r[t] = 1'b1;
      for (int l = 0; l < N_LIT; l++) begin
        logic lv;
        lv = (l < N_IN) ? x[l] : ~x[l-N_IN];
        if (c[t*N_LIT+l] && !lv) r[t] = 1'b0;
      end
    end
    for (int k = 0; k < N_SPC; k++) r[N_GEN+k] = r[N_GEN+k] ^ c[EN_W+k];
    return r;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [N_TERM-1:0] act, input logic [N_TERM-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_en(input int t, input int l);
    img[t*N_LIT+l] = 1'b1;
  endtask

  // R8: highest bit first; R9/R10 checked along the way
  task automatic load(input logic [CFG_W-1:0] c, input logic was_done);
    for (int i = CFG_W - 1; i >= 0; i--) begin
      @(negedge clk);
      shift_en = 1'b1;
      sdi = c[i];
      #1;
      if (i == CFG_W - 1)
        check(done == was_done, "R9 done before first shift", N_TERM'(done), N_TERM'(was_done));
      if (i == CFG_W - 2)
        check(done == 1'b0, "R9 done drops on new load", N_TERM'(done), '0);
      if (i == 0) begin
        check(done == 1'b0, "R9 done low before last edge", N_TERM'(done), '0);
        check(all_terms() == '0, "R10 outputs blanked while shifting", all_terms(), '0);
      end
    end
    @(negedge clk);
    shift_en = 1'b0;
    sdi = 1'b0;
    #1;
    check(done == 1'b1, "R9 done after full load", N_TERM'(done), N_TERM'(1));
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < 8; v++) begin
      logic [N_TERM-1:0] e;
      @(negedge clk);
      in_v = VEC[v];
      #1;
      e = model(img, in_v);
      check(gen_pt == e[N_GEN-1:0], {tag, " R2 R4 general terms"}, all_terms(), e);
      check({oe_lo, oe_up} == e[N_GEN +: N_OE], {tag, " R5 R7 oe terms"}, all_terms(), e);
      check({ptclk, areset, aset} == e[N_TERM-1 -: 3], {tag, " R6 R7 control terms"}, all_terms(), e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    in_v = 36'h3_C3C3_C3C3;
    #1;
    // R11: empty plane, polarity clear
    check(all_terms() == '1, "R11 outputs after reset", all_terms(), '1);
    check(done == 1'b0, "R11 done after reset", N_TERM'(done), '0);

    // directed image
    img = '0;
    set_en(0, 5);                         // R1 true literal
    set_en(1, N_IN + 5);                  // R1 inverted literal
    set_en(2, 3); set_en(2, N_IN + 3);    // R3 conflict
    set_en(4, 0); set_en(4, 1); set_en(4, 2);
    set_en(80, 10); set_en(81, 11); set_en(82, 12); set_en(83, 13);
    img[EN_W + 3] = 1'b1;                 // oe_lower_o[1] inverted
    set_en(84, N_IN + 0); set_en(84, N_IN + 1);
    img[EN_W + 4] = 1'b1;                 // set = in0 | in1
    set_en(85, 7);
    img[EN_W + 6] = 1'b1;                 // clock term empty, inverted -> 0
    load(img, 1'b0);

    for (int p = 0; p < 4; p++) begin
      logic [N_IN-1:0] x;
      x = (p == 0) ? 36'h0_0000_0000 : (p == 1) ? 36'hF_FFFF_FFFF :
          (p == 2) ? 36'h0_0000_2421 : 36'h0_0000_1082;
      @(negedge clk);
      in_v = x;
      #1;
      check(gen_pt[0] == x[5], "R1 true literal", all_terms(), model(img, x));
      check(gen_pt[1] == ~x[5], "R1 inverted literal", all_terms(), model(img, x));
      check(gen_pt[2] == 1'b0, "R3 conflicting literals", all_terms(), model(img, x));
      check(gen_pt[3] == 1'b1, "R2 empty term", all_terms(), model(img, x));
      check(gen_pt[4] == &x[2:0], "R2 three-literal AND", all_terms(), model(img, x));
      check(oe_up == x[11:10], "R5 upper oe terms", all_terms(), model(img, x));
      check(oe_lo == {~x[13], x[12]}, "R5 R7 lower oe terms", all_terms(), model(img, x));
      check(aset == (x[0] | x[1]), "R7 set term as OR", all_terms(), model(img, x));
      check(areset == x[7], "R6 reset term", all_terms(), model(img, x));
      check(ptclk == 1'b0, "R6 R7 clock term", all_terms(), model(img, x));
    end
    sweep("directed");

    // R12: sdi toggling with shift disabled
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      sdi = i[0];
    end
    sdi = 1'b0;
    #1;
    check(done == 1'b1, "R12 done held while idle", N_TERM'(done), N_TERM'(1));
    sweep("R12 after idle sdi");

    // random images
    for (int r = 0; r < 3; r++) begin
      for (int b = 0; b < EN_W; b++) img[b] = (($urandom % 32) == 0);
      for (int k = 0; k < N_SPC; k++) img[EN_W+k] = $urandom % 2;
      load(img, 1'b1);
      sweep("R8 random image");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule